// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block is the interrupt logic of a two-channel serial controller. It gathers six request sources (receive, transmit and external/status events for channel A and for channel B), latches each into a pending bit when that source is enabled, and ranks the sources by a fixed priority. When the master enable is on and an unmasked source is pending, it pulls an active-low request line to the CPU.

On an interrupt-acknowledge pulse, the block marks the winning source as in service and releases the request line. One cycle later it returns the vector byte on an acknowledge data port, optionally with three bits replaced by a code that names the source. An in-service source masks itself and every lower-priority source, so only a higher-priority source can interrupt the service routine. Software ends a service with a command that clears the in-service bit of the highest-priority source in service. Software can poll one pending register that covers both channels. The vector byte can be read back raw through the channel A port, or with the status code through the channel B port.

Top module: `svc_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all pending, enable and in-service bits are 0, the master enable is off, the vector byte is 0x00, `irq_n` is 1 and `ack_vld` is 0.
- R2: Pending bit i sets on the clock edge where `src_req[i]` is 1 and enable bit i is already 1. A request whose enable bit is 0 is ignored. `clr_pend[i]` clears the bit. If a request and a clear arrive in the same cycle, the request wins. `pend_rd` shows all six pending bits.
- R3: `vec_rd_a` always returns the stored vector byte unmodified.
- R4: `vec_rd_b` returns the vector byte with bits 3:1 replaced by the code of the highest-priority eligible source. The codes are: index0 (A receive)=110, index1 (A transmit)=100, index2 (A ext/status)=101, index3 (B receive)=010, index4 (B transmit)=000, index5 (B ext/status)=001. With no eligible source the code is 011.
- R5: A source is eligible when it is pending, enabled, and neither it nor any higher-priority source is in service. `irq_n` is 0 in the cycle after one where the master enable is on, a source is eligible and no acknowledge is given. Otherwise it is 1.
- R6: One cycle after `iack`, `irq_n` is 1 and `ack_vld` is 1. `ack_data` holds the vector with the R4 code when `ack_stat` is 1, and the raw vector when `ack_stat` is 0.
- R7: `iack` sets the in-service bit of the highest-priority eligible source. Equal- and lower-priority sources stay masked while that bit is set. A higher-priority source can still request, which allows nested service.
- R8: `rst_ius` clears only the in-service bit of the highest-priority source that is in service.
- R9: Priority is fixed by index, from index0 (highest) to index5 (lowest).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 6 | Source request pulses, index order as in R4 |
| en_we | input | 1 | Write strobe for the enable mask |
| en_wdata | input | 6 | New enable mask |
| mie_we | input | 1 | Write strobe for the master enable |
| mie_wdata | input | 1 | New master enable |
| vec_we | input | 1 | Write strobe for the vector byte |
| vec_wdata | input | 8 | New vector byte |
| clr_pend | input | 6 | Per-source pending clear pulses |
| rst_ius | input | 1 | Clear the highest-priority in-service bit |
| iack | input | 1 | Interrupt-acknowledge pulse |
| ack_stat | input | 1 | Put the status code into the acknowledge vector |
| irq_n | output | 1 | Active-low interrupt request |
| ack_vld | output | 1 | Acknowledge vector valid |
| ack_data | output | 8 | Acknowledge vector byte |
| pend_rd | output | 6 | Pending bits of both channels |
| vec_rd_a | output | 8 | Raw vector read port |
| vec_rd_b | output | 8 | Vector read port with status code |

## Verification
The assertions check on every cycle that a request line is released after each acknowledge and whenever the master enable is off. They also check that an acknowledge always yields a valid vector, that enabled requests always set their pending bit, that in-service bits change only through an acknowledge or an end-of-service command, and that an end-of-service command never adds in-service bits. Only the bench scenarios can show that the correct source wins, that the status code matches the table, and that nested service works. The scenarios also cover the following: a higher-priority source breaks through during service while a lower one stays masked, and `rst_ius` unwinds the most recent level first.

// File: rtl/svc_irq_pkg.sv
package svc_irq_pkg;
  localparam int NSRC     = 6;
  localparam int CODE_W   = 3;
  localparam int CODE_LSB = 1;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_NONE = 3'b011;

  function automatic code_t src_code(input int idx);
    case (idx)
      0:       src_code = 3'b110;
      1:       src_code = 3'b100;
      2:       src_code = 3'b101;
      3:       src_code = 3'b010;
      4:       src_code = 3'b000;
      5:       src_code = 3'b001;
      default: src_code = CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/svc_irq_bank.sv
module svc_irq_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wdata_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] set_ius_i,
  input  logic         rst_ius_i,
  input  logic         iack_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] ius_o
);
  logic [N-1:0] en_q, pend_q, ius_q, ius_d;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_src
      always_ff @(posedge clk) begin
        if (rst) begin
          pend_q[g] <= 1'b0;
          en_q[g]   <= 1'b0;
        end else begin
          if (req_i[g] && en_q[g]) pend_q[g] <= 1'b1;
          else if (clr_i[g])       pend_q[g] <= 1'b0;
          if (en_we_i)             en_q[g]   <= en_wdata_i[g];
        end
      end

      AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        (req_i[g] && en_q[g]) |=> pend_q[g]); // R2
    end
  endgenerate

  always_comb begin
    logic found;
    found = 1'b0;
    ius_d = ius_q;
    if (rst_ius_i) begin
      for (int i = 0; i < N; i++) begin
        if (ius_q[i] && !found) begin
          ius_d[i] = 1'b0;
          found    = 1'b1;
        end
      end
    end
    ius_d = ius_d | set_ius_i;
  end

  always_ff @(posedge clk) begin
    if (rst) ius_q <= '0;
    else     ius_q <= ius_d;
  end

  AST_IUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!iack_i && !rst_ius_i) |=> $stable(ius_q)); // R7
  AST_IUS_UNWIND: assert property (@(posedge clk) disable iff (rst)
    (rst_ius_i && !iack_i) |=> ($countones(ius_q) <= $countones($past(ius_q)))); // R8

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign ius_o  = ius_q;
endmodule

// File: rtl/svc_irq_prio.sv
module svc_irq_prio
  import svc_irq_pkg::*;
#(
  parameter int N = 6
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] ius_i,
  output logic [N-1:0] top_oh_o,
  output logic         any_o,
  output code_t        code_o
);
  logic [N-1:0] elig;

  always_comb begin
    logic masked;
    masked = 1'b0;
    for (int i = 0; i < N; i++) begin
      masked  = masked | ius_i[i];
      elig[i] = pend_i[i] & en_i[i] & ~masked;
    end
  end

  always_comb begin
    top_oh_o = '0;
    code_o   = CODE_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        top_oh_o = '0;
        top_oh_o[i] = 1'b1;
        code_o   = src_code(i);
      end
    end
  end

  assign any_o = |elig;

  always_comb begin
    AST_TOP_ONEHOT: assert ($onehot0(top_oh_o)); // R9
  end
endmodule

// File: rtl/svc_irq_ctrl.sv
module svc_irq_ctrl
  import svc_irq_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_req,
  input  logic             en_we,
  input  logic [N_SRC-1:0] en_wdata,
  input  logic             mie_we,
  input  logic             mie_wdata,
  input  logic             vec_we,
  input  logic [VEC_W-1:0] vec_wdata,
  input  logic [N_SRC-1:0] clr_pend,
  input  logic             rst_ius,
  input  logic             iack,
  input  logic             ack_stat,
  output logic             irq_n,
  output logic             ack_vld,
  output logic [VEC_W-1:0] ack_data,
  output logic [N_SRC-1:0] pend_rd,
  output logic [VEC_W-1:0] vec_rd_a,
  output logic [VEC_W-1:0] vec_rd_b
);
  localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

  logic [N_SRC-1:0] en_w, pend_w, ius_w, top_oh, set_ius;
  logic             any_elig;
  code_t            code;
  logic [VEC_W-1:0] vec_q, vec_stat, ack_q;
  logic             mie_q, irq_n_q, ack_vld_q;

  assign set_ius = iack ? top_oh : '0;

  svc_irq_bank #(.N(N_SRC)) u_bank (
    .clk(clk), .rst(rst), .req_i(src_req), .en_we_i(en_we),
    .en_wdata_i(en_wdata), .clr_i(clr_pend), .set_ius_i(set_ius),
    .rst_ius_i(rst_ius), .iack_i(iack),
    .en_o(en_w), .pend_o(pend_w), .ius_o(ius_w)
  );

  svc_irq_prio #(.N(N_SRC)) u_prio (
    .pend_i(pend_w), .en_i(en_w), .ius_i(ius_w),
    .top_oh_o(top_oh), .any_o(any_elig), .code_o(code)
  );

  always_comb begin
    vec_stat = vec_q;
    vec_stat[CODE_MSB:CODE_LSB] = code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q     <= '0;
      mie_q     <= 1'b0;
      irq_n_q   <= 1'b1;
      ack_vld_q <= 1'b0;
      ack_q     <= '0;
    end else begin
      if (vec_we) vec_q <= vec_wdata;
      if (mie_we) mie_q <= mie_wdata;
      irq_n_q   <= iack | ~(mie_q & any_elig);
      ack_vld_q <= iack;
      if (iack) ack_q <= ack_stat ? vec_stat : vec_q;
    end
  end

  AST_MIE_GATE: assert property (@(posedge clk) disable iff (rst)
    !mie_q |=> irq_n_q); // R5
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    iack |=> irq_n_q); // R6
  AST_ACK_VALID: assert property (@(posedge clk) disable iff (rst)
    iack |=> ack_vld_q); // R6

  assign irq_n    = irq_n_q;
  assign ack_vld  = ack_vld_q;
  assign ack_data = ack_q;
  assign pend_rd  = pend_w;
  assign vec_rd_a = vec_q;
  assign vec_rd_b = vec_stat;
endmodule

// File: tb/tb_svc_irq_ctrl.sv
module tb_svc_irq_ctrl;
  logic       clk = 1'b0, rst = 1'b1;
  logic [5:0] src_req = '0, en_wdata = '0, clr_pend = '0;
  logic       en_we = 0, mie_we = 0, mie_wdata = 0, vec_we = 0;
  logic [7:0] vec_wdata = '0;
  logic       rst_ius = 0, iack = 0, ack_stat = 0;
  logic       irq_n, ack_vld;
  logic [7:0] ack_data, vec_rd_a, vec_rd_b;
  logic [5:0] pend_rd;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  svc_irq_ctrl dut (.*);

  // behavioural reference
  bit m_pend[6], m_en[6], m_ius[6];
  bit m_mie, m_irqn = 1, m_ackv;
  int m_vec, m_ack;

  function automatic int code_of(int idx);
    int t[7] = '{6, 4, 5, 2, 0, 1, 3};
    return (idx < 0) ? 3 : t[idx];
  endfunction

  function automatic int top_idx();
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j <= i; j++) if (m_ius[j]) return -1;
      if (m_pend[i] && m_en[i]) return i;
    end
    return -1;
  endfunction

  function automatic int with_code(int v, int c);
    return (v & 8'hF1) | (c << 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_pend[i]) begin m_pend[i] = 0; m_en[i] = 0; m_ius[i] = 0; end
      m_mie = 0; m_irqn = 1; m_ackv = 0; m_vec = 0; m_ack = 0;
    end else begin
      int t;
      bit found;
      t = top_idx();
      m_irqn = iack || !(m_mie && t >= 0);
      m_ackv = iack;
      if (iack) m_ack = ack_stat ? with_code(m_vec, code_of(t)) : m_vec;
      found = 0;
      if (rst_ius)
        for (int i = 0; i < 6; i++)
          if (m_ius[i] && !found) begin m_ius[i] = 0; found = 1; end
      if (iack && t >= 0) m_ius[t] = 1;
      for (int i = 0; i < 6; i++) begin
        if (src_req[i] && m_en[i]) m_pend[i] = 1;
        else if (clr_pend[i])      m_pend[i] = 0;
      end
      if (en_we) foreach (m_en[i]) m_en[i] = en_wdata[i];
      if (vec_we) m_vec = vec_wdata;
      if (mie_we) m_mie = mie_wdata;
    end
  end

  task automatic chk(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      int pv;
      pv = 0;
      for (int i = 0; i < 6; i++) pv |= int'(m_pend[i]) << i;
      chk("R5 irq_n", irq_n, m_irqn);
      chk("R6 ack_vld", ack_vld, m_ackv);
      chk("R6 ack_data", ack_data, m_ack);
      chk("R2 pend_rd", pend_rd, pv);
      chk("R3 vec_rd_a", vec_rd_a, m_vec);
      chk("R4 vec_rd_b", vec_rd_b, with_code(m_vec, code_of(top_idx())));
    end
    if (cyc > 5000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_strobes();
    src_req = '0; clr_pend = '0; en_we = 0; mie_we = 0; vec_we = 0;
    rst_ius = 0; iack = 0;
  endtask

  task automatic pulse_req(logic [5:0] m);
    src_req = m; tick(); clear_strobes(); tick(3);
  endtask

  task automatic do_ack();
    iack = 1; tick(); clear_strobes();
  endtask

  initial begin
    tick(3);
    rst = 0;
    #1;
    chk("R1 irq_n", irq_n, 1); chk("R1 ack_vld", ack_vld, 0);
    chk("R1 pend", pend_rd, 0); chk("R1 vec", vec_rd_a, 0);
    tick();

    vec_we = 1; vec_wdata = 8'hA5; tick(); clear_strobes(); tick();
    chk("R3 raw vector", vec_rd_a, 8'hA5);
    chk("R4 none code", vec_rd_b, 8'hA7);

    pulse_req(6'h10);
    chk("R2 disabled request ignored", pend_rd, 0);

    en_we = 1; en_wdata = 6'h3F; mie_we = 1; mie_wdata = 1; tick(); clear_strobes();
    ack_stat = 1;
    pulse_req(6'h10);
    chk("R2 pending set", pend_rd, 6'h10);
    chk("R4 B transmit code", vec_rd_b, 8'hA1);
    chk("R5 request low", irq_n, 0);

    do_ack();
    chk("R6 release", irq_n, 1); chk("R6 valid", ack_vld, 1);
    chk("R6 vector status", ack_data, 8'hA1);
    tick();

    pulse_req(6'h20);
    chk("R7 lower masked", irq_n, 1);
    pulse_req(6'h01);
    chk("R7 higher nests", irq_n, 0);
    chk("R9 A receive wins", vec_rd_b, 8'hAD);
    do_ack();
    chk("R6 nested vector", ack_data, 8'hAD);
    tick(2);

    clr_pend = 6'h11; tick(); clear_strobes();
    rst_ius = 1; tick(); clear_strobes(); tick(2);
    chk("R8 still masked", irq_n, 1);
    chk("R8 none eligible", vec_rd_b, 8'hA7);
    rst_ius = 1; tick(); clear_strobes(); tick(2);
    chk("R8 unwound", irq_n, 0);
    chk("R8 B ext code", vec_rd_b, 8'hA3);

    pulse_req(6'h0E);
    chk("R9 A transmit over others", vec_rd_b, 8'hA9);

    src_req = 6'h02; clr_pend = 6'h02; tick(); clear_strobes(); tick();
    chk("R2 set beats clear", pend_rd[1], 1);
    clr_pend = 6'h3F; tick(); clear_strobes(); tick(2);
    chk("R2 cleared", pend_rd, 0);

    pulse_req(6'h08);
    en_we = 1; en_wdata = 6'h37; tick(); clear_strobes(); tick(2);
    chk("R5 disabled source not eligible", irq_n, 1);
    en_we = 1; en_wdata = 6'h3F; tick(); clear_strobes(); tick(2);
    chk("R5 re-enabled", irq_n, 0);
    mie_we = 1; mie_wdata = 0; tick(); clear_strobes(); tick(2);
    chk("R5 master off", irq_n, 1);

    ack_stat = 0;
    do_ack();
    chk("R6 raw vector", ack_data, 8'hA5);
    tick(4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule